// File: doc/BRIEF.md
# I2C Host SCL Clock Generator

This block produces the serial clock for an I2C host from an 8-bit divisor. The clock line is open-drain. The block has a drive-low enable output, and it reads the wire back through an SCL input. A low phase is timed in system clocks, starting at the cycle in which the block begins pulling the line low. Because of this, the bus fall time is part of that count. The high phase is different: its count starts only after the synchronised wire reads high. A slow rise, or a target that holds the clock low, therefore lengthens the period instead of shortening the high time.

Each phase lasts (BAUD + 5) system clocks. The SCL frequency is therefore fCLK / (10 + 2·BAUD + fCLK·tRISE). The rise term also absorbs the synchroniser and detection delay.

A separate status flag compares the programmed low time with the minimum low time of the selected speed mode. Each minimum is converted to whole clock cycles, rounded up, when the design is elaborated.

The state machine has four states:
- IDLE: the line is released.
- LOW: the block drives the line low.
- WAIT_HI: the line is released and the block waits for it to read high.
- HIGH: the high time is being counted.

It has these transitions:
- enable: IDLE to LOW
- low_done: LOW to WAIT_HI
- line_high: WAIT_HI to HIGH
- high_done: HIGH to LOW
- disable: any state to IDLE

A new divisor value is latched on each entry to LOW, so a period in progress is never cut short.

Top module: `scl_clock_gen`

## Requirements
- R1: During and directly after reset, the drive-low output is 0, both edge pulses are 0 and the short-low flag is 0.
- R2: Each low phase keeps the drive-low output at 1 for exactly BAUD+5 consecutive cycles.
- R3: After the line is released, high counting begins only once the two-flop-synchronised wire reads high. If the wire is held low for S cycles after release, the rise pulse comes S+3 cycles after the first released cycle.
- R4: The high phase lasts BAUD+5 cycles, counted from the rise pulse. If enable is still 1, the next low phase (with its fall pulse) follows immediately.
- R5: The fall pulse is 1 for exactly one cycle, the first cycle of each low phase. The rise pulse is 1 for exactly one cycle, the first counted high cycle.
- R6: While enable is 0, the line is released and no pulse occurs. Clearing enable in any state releases the line in the following cycle.
- R7: BAUD is sampled only on entry to a low phase. A change in the middle of a period affects only the next period.
- R8: The short-low flag is registered one cycle after its inputs. It is 1 when BAUD+5 is less than ceil(tmin·fCLK). The mode encodings are 00 = standard (tmin 4700 ns), 01 = fast (1300 ns), 10 = fast-plus (500 ns), and 11, which is treated as fast-plus. At 50 MHz the thresholds are 235, 65 and 25 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Runs the generator when 1 |
| mode_i | input | 2 | Speed mode select |
| baud_i | input | 8 | Divisor BAUD |
| scl_i | input | 1 | Sensed level of the SCL wire |
| scl_drive_low_o | output | 1 | 1 pulls SCL low (open-drain enable) |
| scl_fall_o | output | 1 | One-cycle pulse at each driven falling edge |
| scl_rise_o | output | 1 | One-cycle pulse at each detected rising edge |
| low_short_o | output | 1 | Programmed low time is below the mode minimum |

## Verification
The clock is run with several divisors, including 0, a middle value and 255. Each divisor is combined with different amounts of extra time for which a modelled target holds the wire low. The divisor variation shows whether the low and high counts follow BAUD+5. The hold-low variation shows whether the high count waits for the sensed wire, rather than starting when the line is released. A divisor change in the middle of a low phase checks that the latch timing is correct. Disable pulses in the middle of the low and high phases check that the line is released promptly. For each mode, the flag is set one step below and exactly at its threshold, which exposes errors in the rounding and in the comparison.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOW     = 2'd1,
        ST_WAIT_HI = 2'd2,
        ST_HIGH    = 2'd3
    } scl_state_e;

    typedef enum logic [1:0] {
        SPD_STD   = 2'b00,
        SPD_FAST  = 2'b01,
        SPD_FPLUS = 2'b10,
        SPD_RSVD  = 2'b11
    } spd_mode_e;

    // Cycles added to BAUD for each counted phase.
    localparam int unsigned PHASE_EXTRA = 5;

    // Minimum low times per mode, in nanoseconds.
    localparam int unsigned TLOW_STD_NS   = 4700;
    localparam int unsigned TLOW_FAST_NS  = 1300;
    localparam int unsigned TLOW_FPLUS_NS = 500;

    // Converts a time in ns to a count of clock cycles, rounding up.
    function automatic int unsigned ns_to_cycles(input int unsigned clk_hz,
                                                 input int unsigned t_ns);
        longint unsigned prod;
        prod = longint'(clk_hz) * longint'(t_ns);
        return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
    endfunction

endpackage

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] shreg;

    // The wire idles high because of its pull-up, so reset to ones.
    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) shreg <= '1;
                else         shreg <= d_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) shreg <= '1;
                else         shreg <= {shreg[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = shreg[STAGES-1];
endmodule

// File: rtl/scl_low_check.sv
module scl_low_check
    import scl_gen_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000,
    parameter int          BAUD_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [BAUD_W-1:0] baud_i,
    input  logic [1:0]        mode_i,
    output logic              short_o
);
    localparam int unsigned MIN_STD   = ns_to_cycles(CLK_HZ, TLOW_STD_NS);
    localparam int unsigned MIN_FAST  = ns_to_cycles(CLK_HZ, TLOW_FAST_NS);
    localparam int unsigned MIN_FPLUS = ns_to_cycles(CLK_HZ, TLOW_FPLUS_NS);

    logic [31:0] need_cyc;
    logic [31:0] have_cyc;

    always_comb begin
        unique case (spd_mode_e'(mode_i))
            SPD_STD:   need_cyc = MIN_STD;
            SPD_FAST:  need_cyc = MIN_FAST;
            SPD_FPLUS: need_cyc = MIN_FPLUS;
            SPD_RSVD:  need_cyc = MIN_FPLUS;
            default:   need_cyc = MIN_FPLUS;
        endcase
    end

    assign have_cyc = 32'(baud_i) + 32'(PHASE_EXTRA);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) short_o <= 1'b0;
        else         short_o <= (have_cyc < need_cyc);
    end

    // R8: once the longest low time is programmed, the flag clears after one cycle.
    p_max_baud_ok_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (baud_i == '1) |=> !short_o);
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int BAUD_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [BAUD_W-1:0] baud_i,
    input  logic              scl_hi_i,
    output logic              drive_low_o,
    output logic              fall_o,
    output logic              rise_o
);
    localparam int CNT_W = BAUD_W + 1;

    scl_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [BAUD_W-1:0] baud_q, baud_d;
    logic [CNT_W-1:0]  last_cnt;

    // The final count value of a phase: BAUD+5 cycles means counts 0 to BAUD+4.
    assign last_cnt = {1'b0, baud_q} + CNT_W'(PHASE_EXTRA - 1);

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            baud_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            baud_q  <= baud_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        baud_d  = baud_q;
        if (!en_i) begin
            state_d = ST_IDLE;                  // disable
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin                  // enable
                    state_d = ST_LOW;
                    cnt_d   = '0;
                    baud_d  = baud_i;
                end
                ST_LOW: begin
                    if (cnt_q == last_cnt) begin   // low_done
                        state_d = ST_WAIT_HI;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_WAIT_HI: begin
                    if (scl_hi_i) begin         // line_high
                        state_d = ST_HIGH;
                        cnt_d   = '0;
                    end
                end
                ST_HIGH: begin
                    if (cnt_q == last_cnt) begin   // high_done
                        state_d = ST_LOW;
                        cnt_d   = '0;
                        baud_d  = baud_i;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Output logic
    always_comb begin
        drive_low_o = 1'b0;
        fall_o      = 1'b0;
        rise_o      = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_LOW: begin
                drive_low_o = 1'b1;
                fall_o      = (cnt_q == '0);
            end
            ST_WAIT_HI: ;
            ST_HIGH:    rise_o = (cnt_q == '0);
            default:    ;
        endcase
    end

    // R5: each pulse lasts a single cycle.
    p_fall_one_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |=> !fall_o);
    p_rise_one_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);
    // R6: a cleared enable releases the line in the next cycle.
    p_release_when_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (!drive_low_o && !fall_o && !rise_o));
    // R3: a rise is reported only after the synchronised wire has read high.
    p_rise_after_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |-> $past(scl_hi_i));
    // R2: the low count never goes beyond its final value.
    p_low_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        drive_low_o |-> (cnt_q <= last_cnt));
endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen #(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int          BAUD_W      = 8,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [1:0]        mode_i,
    input  logic [BAUD_W-1:0] baud_i,
    input  logic              scl_i,
    output logic              scl_drive_low_o,
    output logic              scl_fall_o,
    output logic              scl_rise_o,
    output logic              low_short_o
);
    logic scl_hi;

    scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (scl_i),
        .q_o    (scl_hi)
    );

    scl_phase_fsm #(.BAUD_W(BAUD_W)) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (en_i),
        .baud_i      (baud_i),
        .scl_hi_i    (scl_hi),
        .drive_low_o (scl_drive_low_o),
        .fall_o      (scl_fall_o),
        .rise_o      (scl_rise_o)
    );

    scl_low_check #(.CLK_HZ(CLK_HZ), .BAUD_W(BAUD_W)) u_chk (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .baud_i  (baud_i),
        .mode_i  (mode_i),
        .short_o (low_short_o)
    );
endmodule

// File: tb/scl_clock_gen_tb.sv
module scl_clock_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [7:0] baud = 8'd0;
    logic       drv, fall_p, rise_p, short_f;
    int         hold_len = 0;
    int         hold_left = 0;
    logic       scl_line;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct { int kind; int val; } item_t;   // kind: 0 low (R2), 1 wait (R3), 2 high (R4)
    item_t exp_q[$];

    always #10 clk = ~clk;

    assign scl_line = !drv && (hold_left == 0);

    // Model of a target that holds the clock low for hold_len cycles after release.
    always @(posedge clk) begin
        if (drv) hold_left <= hold_len;
        else if (hold_left > 0) hold_left <= hold_left - 1;
    end

    scl_clock_gen u_dut (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode), .baud_i(baud),
        .scl_i(scl_line), .scl_drive_low_o(drv), .scl_fall_o(fall_p),
        .scl_rise_o(rise_p), .low_short_o(short_f));

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: measures phase lengths at the falling clock edge and compares them with the queue.
    int  low_run = 0, wait_run = 0, high_run = 0;
    bit  in_wait = 0, in_high = 0, prev_fall = 0, prev_rise = 0;

    task automatic score(input int kind, input int val);
        item_t e;
        string nm;
        nm = (kind == 0) ? "R2" : (kind == 1) ? "R3" : "R4";
        if (exp_q.size() == 0) begin
            check(0, nm, val, -1);
        end else begin
            e = exp_q.pop_front();
            check(e.kind == kind && e.val == val, nm, val, e.val);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (fall_p) check(!prev_fall && drv, "R5", int'(prev_fall), 0);
            if (rise_p) check(!prev_rise && !drv, "R5", int'(prev_rise), 0);
            prev_fall = fall_p;
            prev_rise = rise_p;
            if (!en) begin
                low_run = 0; in_wait = 0; in_high = 0;
            end else begin
                if (drv) begin
                    if (in_high) begin score(2, high_run); in_high = 0; end
                    low_run++;
                end else begin
                    if (low_run > 0) begin
                        score(0, low_run); low_run = 0;
                        in_wait = 1; wait_run = 0;
                    end
                    if (in_wait) begin
                        if (rise_p) begin
                            score(1, wait_run); in_wait = 0;
                            in_high = 1; high_run = 1;
                        end else wait_run++;
                    end else if (in_high) high_run++;
                end
            end
        end
    end

    task automatic push(input int k, input int v);
        item_t e;
        e.kind = k; e.val = v;
        exp_q.push_back(e);
    endtask

    task automatic wait_rises(input int n);
        int seen = 0;
        while (seen < n) begin
            @(negedge clk);
            if (rise_p) seen++;
        end
    endtask

    task automatic stop_gen();
        #2 en = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    // Two full lows and one full high, then a disable during the second high.
    task automatic run_case(input int b, input int s);
        @(negedge clk);
        #2 baud = 8'(b); hold_len = s;
        push(0, b + 5); push(1, s + 3); push(2, b + 5);
        push(0, b + 5); push(1, s + 3);
        en = 1'b1;
        wait_rises(2);
        stop_gen();
    endtask

    task automatic flag_case(input logic [1:0] m, input int b, input bit expv);
        @(negedge clk);
        #2 mode = m; baud = 8'(b);
        @(negedge clk);
        check(short_f == expv, "R8", int'(short_f), int'(expv));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!drv && !fall_p && !rise_p && !short_f, "R1", int'(drv), 0);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check(!drv && !fall_p && !rise_p, "R1", int'(drv), 0);

        // R6: no activity while disabled.
        begin
            bit quiet = 1;
            repeat (30) begin
                @(negedge clk);
                if (drv || fall_p || rise_p) quiet = 0;
            end
            check(quiet, "R6", int'(quiet), 1);
        end

        run_case(0, 0);
        run_case(7, 0);
        run_case(7, 5);
        run_case(30, 20);
        run_case(255, 2);

        // R7: a divisor change in the low phase applies only to the next low phase.
        @(negedge clk);
        #2 baud = 8'd10; hold_len = 0;
        push(0, 15); push(1, 3); push(2, 15); push(0, 7); push(1, 3);
        en = 1'b1;
        begin
            do @(negedge clk); while (!fall_p);
        end
        #2 baud = 8'd2;
        wait_rises(2);
        stop_gen();

        // R6: disable in the middle of a low phase.
        @(negedge clk);
        #2 baud = 8'd20; en = 1'b1;
        repeat (4) @(negedge clk);
        check(drv, "R6", int'(drv), 1);
        #2 en = 1'b0;
        @(negedge clk);
        check(!drv, "R6", int'(drv), 0);
        repeat (4) @(negedge clk);

        // R8: the flag on each side of each mode threshold.
        flag_case(2'b00, 229, 1'b1);
        flag_case(2'b00, 230, 1'b0);
        flag_case(2'b01, 59, 1'b1);
        flag_case(2'b01, 60, 1'b0);
        flag_case(2'b10, 19, 1'b1);
        flag_case(2'b10, 20, 1'b0);
        flag_case(2'b11, 19, 1'b1);
        flag_case(2'b11, 20, 1'b0);
        flag_case(2'b00, 255, 1'b0);

        check(exp_q.size() == 0, "R2", exp_q.size(), 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule